// File: doc/BRIEF.md
# Keyed Register Write Guard

This block protects a small register file of a clock-style peripheral against stray writes. Software may read every register freely. A write to a protected register lands only after an explicit handshake. Software first writes a 16-bit key to a dedicated key/status register. It then polls that register until the unlocked bit appears. Finally it checks that the write-ready flag is high and issues exactly one protected write. That write uses up the unlock, so the next protected write needs a fresh handshake.

The write-ready flag stands in for the latency of a slow clock domain. After every accepted write it stays low for a fixed number of cycles. Any protected write made while the block is locked or while write-ready is low is discarded, and a sticky error bit records it. Reading the key/status register with the read strobe clears that error bit. Four plain registers serve as the protected targets: a control register, an alarm-compare word, a hibernate word and a scratch word.

Top module: `keyed_write_guard`

## Requirements
- R1: After reset the block is locked, so key/status bit 31 reads 0. Control bit 7 (write-ready) reads 1, key/status bit 0 (error) reads 0, and all protected registers read 0. The offsets are control 0x00, alarm 0x04, hibernate 0x20, scratch 0x34 and key/status 0x3C.
- R2: A write to 0x3C whose low 16 bits equal 0xA55A requests an unlock, and the upper 16 bits are ignored. Key/status bit 31 reads 0 for the first UNLOCK_DLY-1 cycles after the write edge. It reads 1 from the UNLOCK_DLY-th clock edge after the write edge onward.
- R3: A write to 0x3C with any other low 16 bits clears bit 31 by the next cycle. It also cancels a pending unlock, so bit 31 stays 0 afterwards.
- R4: A protected write made while bit 31 is 1 and write-ready is 1 stores the write data. In the control register only bits 0, 2, 5 and 6 are stored. Bit 7 of the control register always reads write-ready, and its other bits read 0.
- R5: An accepted protected write consumes the unlock. Bit 31 reads 0 after that write edge, and a second protected write without a new key is dropped.
- R6: After an accepted write, write-ready reads 0 and returns to 1 at the WR_LAT-th clock edge after the write edge.
- R7: A protected write made while locked or while write-ready is 0 leaves the target register unchanged. It sets the sticky error bit (0x3C bit 0) and does not consume an unlock that is already granted.
- R8: The error bit reads back unchanged when 0x3C is read without the read strobe. A read of 0x3C with the read strobe returns the error bit as 1 and clears it after that edge.
- R9: A key write that lands on the same edge where a pending unlock would complete takes priority. A matching key restarts the full UNLOCK_DLY delay, and a wrong key leaves the block locked.
- R10: Writes to unmapped offsets change no register, set no error and do not consume a granted unlock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, needed only for the clear-on-read of the error bit |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |

## Verification
Two things can happen on the same edge: the unlock delay expires while a new key write arrives. The bench provokes this by placing a second key write exactly UNLOCK_DLY-1 cycles after the first. It runs this once with the correct key and once with a corrupted key. In the first case the unlocked bit must stay 0 at the expected expiry and rise a full delay later. In the second case it must never rise. A related overlap is an unlock that completes while write-ready is still low from an earlier write. The bench judges that case by checking that the blocked write raises the error and leaves the grant intact.

// File: rtl/kg_pkg.sv
package kg_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned N_PROT  = 4;

  localparam logic [7:0] OFF_CTRL    = 8'h00;
  localparam logic [7:0] OFF_ALARM   = 8'h04;
  localparam logic [7:0] OFF_HIB     = 8'h20;
  localparam logic [7:0] OFF_SCRATCH = 8'h34;
  localparam logic [7:0] OFF_KEY     = 8'h3C;

  localparam logic [15:0] UNLOCK_KEY = 16'hA55A;

  localparam int unsigned BIT_UNLOCKED = 31;
  localparam int unsigned BIT_ERROR    = 0;
  localparam int unsigned BIT_READY    = 7;

  // writable bits of the control word: run, alarm enable, tick irq enable, tick flag
  localparam logic [DATA_W-1:0] CTRL_MASK = 32'h0000_0065;

  function automatic logic [7:0] prot_offset(input int unsigned idx);
    case (idx)
      0:       return OFF_CTRL;
      1:       return OFF_ALARM;
      2:       return OFF_HIB;
      default: return OFF_SCRATCH;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] prot_mask(input int unsigned idx);
    return (idx == 0) ? CTRL_MASK : {DATA_W{1'b1}};
  endfunction
endpackage

// File: rtl/kg_countdown.sv
// Reloadable down-counter; fire is high in the cycle whose edge ends the delay.
// DELAY must be at least 1.
module kg_countdown #(
  parameter int unsigned DELAY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cancel,
  output logic fire
);
  localparam int unsigned CW = $clog2(DELAY + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;
  logic          running;

  assign running = (cnt_q != '0);
  assign fire    = (cnt_q == CW'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (start) begin
      cnt_d = CW'(DELAY);
    end else if (cancel) begin
      cnt_d = '0;
    end else if (running) begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  assign cnt_en = start | cancel | running;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/kg_unlock.sv
// Key comparison and one-shot grant.
module kg_unlock #(
  parameter int unsigned UNLOCK_DLY = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_wr,
  input  logic [15:0] key_val,
  input  logic        consume,
  output logic        unlocked
);
  import kg_pkg::*;

  logic key_ok;
  logic delay_done;
  logic grant_q;
  logic grant_d;
  logic grant_en;

  assign key_ok = (key_val == UNLOCK_KEY);

  kg_countdown #(.DELAY(UNLOCK_DLY)) u_delay (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (key_wr & key_ok),
    .cancel (key_wr & ~key_ok),
    .fire   (delay_done)
  );

  // a key write of either kind overrides a completion on the same edge
  always_comb begin
    grant_d = grant_q;
    if (key_wr || consume) begin
      grant_d = 1'b0;
    end else if (delay_done) begin
      grant_d = 1'b1;
    end
  end

  assign grant_en = key_wr | consume | delay_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= 1'b0;
    end else if (grant_en) begin
      grant_q <= grant_d;
    end
  end

  assign unlocked = grant_q;
endmodule

// File: rtl/kg_ready.sv
// Write-ready flag: low for WR_LAT edges after each accepted write.
module kg_ready #(
  parameter int unsigned WR_LAT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  output logic ready
);
  logic lat_done;
  logic rdy_q;
  logic rdy_d;
  logic rdy_en;

  kg_countdown #(.DELAY(WR_LAT)) u_lat (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (accept),
    .cancel (1'b0),
    .fire   (lat_done)
  );

  always_comb begin
    rdy_d = rdy_q;
    if (accept) begin
      rdy_d = 1'b0;
    end else if (lat_done) begin
      rdy_d = 1'b1;
    end
  end

  assign rdy_en = accept | lat_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b1;
    end else if (rdy_en) begin
      rdy_q <= rdy_d;
    end
  end

  assign ready = rdy_q;
endmodule

// File: rtl/kg_regbank.sv
// Protected storage words with per-word address decode and write mask.
module kg_regbank #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic [ADDR_W-1:0]                         addr,
  input  logic [kg_pkg::DATA_W-1:0]                 wdata,
  input  logic                                      wr_ok,
  output logic [kg_pkg::N_PROT-1:0]                 hit,
  output logic [kg_pkg::N_PROT-1:0][kg_pkg::DATA_W-1:0] q
);
  import kg_pkg::*;

  for (genvar g = 0; g < N_PROT; g++) begin : g_word
    localparam logic [DATA_W-1:0] MASK = prot_mask(g);

    logic [DATA_W-1:0] word_q;
    logic [DATA_W-1:0] word_d;
    logic              word_en;

    assign hit[g]  = (addr == ADDR_W'(prot_offset(g)));
    assign word_en = wr_ok & hit[g];
    assign word_d  = wdata & MASK;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (word_en) begin
        word_q <= word_d;
      end
    end

    assign q[g] = word_q;
  end
endmodule

// File: rtl/keyed_write_guard.sv
module keyed_write_guard #(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned UNLOCK_DLY = 4,
  parameter int unsigned WR_LAT     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [31:0]       bus_rdata
);
  import kg_pkg::*;

  logic                            key_hit;
  logic                            key_wr;
  logic [N_PROT-1:0]               prot_hit;
  logic [N_PROT-1:0][DATA_W-1:0]   prot_q;
  logic                            prot_wr;
  logic                            accept;
  logic                            drop;
  logic                            unlocked;
  logic                            wr_ready;
  logic                            err_q;
  logic                            err_d;
  logic                            err_en;
  logic                            err_rd;

  assign key_hit = (bus_addr == ADDR_W'(OFF_KEY));
  assign key_wr  = bus_we & key_hit;
  assign prot_wr = bus_we & (|prot_hit);
  assign accept  = prot_wr & unlocked & wr_ready;
  assign drop    = prot_wr & ~(unlocked & wr_ready);
  assign err_rd  = bus_re & key_hit;

  kg_unlock #(.UNLOCK_DLY(UNLOCK_DLY)) u_unlock (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_wr   (key_wr),
    .key_val  (bus_wdata[15:0]),
    .consume  (accept),
    .unlocked (unlocked)
  );

  kg_ready #(.WR_LAT(WR_LAT)) u_ready (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept),
    .ready  (wr_ready)
  );

  kg_regbank #(.ADDR_W(ADDR_W)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .wr_ok (accept),
    .hit   (prot_hit),
    .q     (prot_q)
  );

  // sticky error: a blocked write sets it, a strobed status read clears it
  always_comb begin
    err_d = err_q;
    if (drop) begin
      err_d = 1'b1;
    end else if (err_rd) begin
      err_d = 1'b0;
    end
  end

  assign err_en = drop | err_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (err_en) begin
      err_q <= err_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (key_hit) begin
      bus_rdata[BIT_UNLOCKED] = unlocked;
      bus_rdata[BIT_ERROR]    = err_q;
    end
    for (int i = 0; i < N_PROT; i++) begin
      if (prot_hit[i]) begin
        bus_rdata = prot_q[i];
      end
    end
    if (prot_hit[0]) begin
      bus_rdata[BIT_READY] = wr_ready;
    end
  end
endmodule

// File: rtl/kg_checker.sv
module kg_checker #(
  parameter int unsigned ADDR_W = 8
) (
  input logic                                        clk,
  input logic                                        rst_n,
  input logic [ADDR_W-1:0]                           bus_addr,
  input logic [31:0]                                 bus_wdata,
  input logic                                        bus_we,
  input logic [kg_pkg::N_PROT-1:0]                   prot_hit,
  input logic [kg_pkg::N_PROT-1:0][kg_pkg::DATA_W-1:0] prot_q,
  input logic                                        unlocked,
  input logic                                        wr_ready,
  input logic                                        err_q
);
  import kg_pkg::*;

  logic c_prot_wr;
  logic c_good;
  logic c_bad_key;

  assign c_prot_wr = bus_we && (prot_hit != '0);
  assign c_good    = c_prot_wr && unlocked && wr_ready;
  assign c_bad_key = bus_we && (bus_addr == ADDR_W'(OFF_KEY)) &&
                     (bus_wdata[15:0] != UNLOCK_KEY);

  assert_accept_consumes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    c_good |=> !unlocked);

  assert_accept_lowers_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    c_good |=> !wr_ready);

  assert_drop_sets_error_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (c_prot_wr && !c_good) |=> err_q);

  assert_drop_keeps_words_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (c_prot_wr && !c_good) |=> $stable(prot_q));

  assert_bad_key_locks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    c_bad_key |=> !unlocked);

  assert_idle_keeps_words_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !c_prot_wr |=> $stable(prot_q));
endmodule

bind keyed_write_guard kg_checker #(.ADDR_W(ADDR_W)) u_kg_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_we    (bus_we),
  .prot_hit  (prot_hit),
  .prot_q    (prot_q),
  .unlocked  (unlocked),
  .wr_ready  (wr_ready),
  .err_q     (err_q)
);

// File: tb/keyed_write_guard_tb_top.sv
module keyed_write_guard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 8;
  localparam int UD  = 4;
  localparam int WL  = 8;
  localparam logic [7:0] A_CTRL = 8'h00, A_ALARM = 8'h04, A_HIB = 8'h20,
                         A_SCR = 8'h34, A_KEY = 8'h3C;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] bus_addr;
  logic [31:0]   bus_wdata;
  logic          bus_we;
  logic          bus_re;
  logic [31:0]   bus_rdata;

  int checks;
  int fails;
  logic done;

  keyed_write_guard #(.ADDR_W(AW), .UNLOCK_DLY(UD), .WR_LAT(WL)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [31:0] v);
    bus_addr = a; bus_re = 1'b0;
    #1 v = bus_rdata;
  endtask

  task automatic rd_clear(output logic [31:0] v);
    bus_addr = A_KEY; bus_re = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic unlock();
    wr(A_KEY, 32'h0000_A55A);
    idle(UD);
  endtask

  function automatic logic [7:0] offs(input int i);
    case (i)
      0: return A_CTRL;
      1: return A_ALARM;
      2: return A_HIB;
      default: return A_SCR;
    endcase
  endfunction

  function automatic logic [31:0] expect_word(input int i, input logic [31:0] d, input logic rdy);
    if (i == 0) return (d & 32'h65) | {24'h0, rdy, 7'h0};
    return d;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] pats [6];
    checks = 0; fails = 0; done = 1'b0;
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'hA5A5_A5A5; pats[2] = 32'h5A5A_5A5A;
    pats[3] = 32'h0000_0001; pats[4] = 32'h8000_0000; pats[5] = 32'h1234_5678;
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; bus_re = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    for (int i = 0; i < 4; i++) begin
      peek(offs(i), v);
      chk("R1 word", v, (i == 0) ? 32'h80 : 32'h0);
    end
    peek(A_KEY, v); chk("R1 status", v, 32'h0);

    // R7 locked writes dropped, R8 clear on strobed read
    for (int i = 0; i < 4; i++) begin
      wr(offs(i), 32'hFFFF_FFFF);
      peek(offs(i), v); chk("R7 locked word", v, (i == 0) ? 32'h80 : 32'h0);
    end
    peek(A_KEY, v); chk("R7 error set", v, 32'h1);
    peek(A_KEY, v); chk("R8 plain read keeps", v, 32'h1);
    rd_clear(v);    chk("R8 strobed read value", v, 32'h1);
    peek(A_KEY, v); chk("R8 cleared", v, 32'h0);

    // R2 unlock delay timing
    wr(A_KEY, 32'h0000_A55A);
    for (int k = 0; k <= UD; k++) begin
      peek(A_KEY, v); chk("R2 delay", {31'h0, v[31]}, {31'h0, (k == UD)});
      if (k < UD) idle(1);
    end

    // R4 R5 R6 sweep over words and patterns
    for (int i = 0; i < 4; i++) begin
      for (int p = 0; p < 6; p++) begin
        unlock();
        wr(offs(i), pats[p]);
        peek(A_KEY, v); chk("R5 consumed", {31'h0, v[31]}, 32'h0);
        for (int k = 0; k <= WL; k++) begin
          peek(A_CTRL, v); chk("R6 ready", {31'h0, v[7]}, {31'h0, (k == WL)});
          if (k < WL) idle(1);
        end
        peek(offs(i), v); chk("R4 stored", v, expect_word(i, pats[p], 1'b1));
        wr(offs(i), ~pats[p]);
        peek(offs(i), v); chk("R5 second dropped", v, expect_word(i, pats[p], 1'b1));
        rd_clear(v); chk("R7 error after second", v, 32'h1);
      end
    end

    // R3 single-bit key corruptions
    for (int b = 0; b < 16; b++) begin
      wr(A_KEY, 32'h0000_A55A ^ (32'h1 << b));
      idle(UD + 2);
      peek(A_KEY, v); chk("R3 bad key", v, 32'h0);
    end
    wr(A_KEY, 32'h0000_A55A); idle(2);
    wr(A_KEY, 32'h0000_A55B); idle(UD + 2);
    peek(A_KEY, v); chk("R3 pending cancelled", v, 32'h0);
    wr(A_KEY, 32'hFFFF_A55A); idle(UD);
    peek(A_KEY, v); chk("R2 upper bits ignored", v, 32'h8000_0000);
    wr(A_KEY, 32'h0000_0000);
    peek(A_KEY, v); chk("R3 relock", v, 32'h0);

    // R9 key write on the completion edge
    wr(A_KEY, 32'h0000_A55A); idle(UD - 1);
    wr(A_KEY, 32'h0000_A55A);
    for (int k = 0; k <= UD; k++) begin
      peek(A_KEY, v); chk("R9 restart", {31'h0, v[31]}, {31'h0, (k == UD)});
      if (k < UD) idle(1);
    end
    wr(A_KEY, 32'h0000_A55A); idle(UD - 1);
    wr(A_KEY, 32'h0000_5AA5); idle(UD + 2);
    peek(A_KEY, v); chk("R9 bad key wins", v, 32'h0);

    // R7 unlock granted while ready still low
    unlock();
    wr(A_SCR, 32'hCAFE_0001);
    wr(A_KEY, 32'h0000_A55A); idle(UD);
    wr(A_SCR, 32'hDEAD_0002);
    peek(A_SCR, v); chk("R7 ready-low drop", v, 32'hCAFE_0001);
    rd_clear(v); chk("R7 grant kept, error set", v, 32'h8000_0001);
    idle(1);
    peek(A_CTRL, v); chk("R6 ready back", {31'h0, v[7]}, 32'h1);
    wr(A_SCR, 32'hBEEF_0003);
    peek(A_SCR, v); chk("R7 retry accepted", v, 32'hBEEF_0003);
    idle(WL);

    // R10 unmapped write
    unlock();
    wr(8'h10, 32'hFFFF_FFFF);
    peek(A_KEY, v); chk("R10 no error, grant kept", v, 32'h8000_0000);
    peek(A_HIB, v); chk("R10 hib unchanged", v, 32'h1234_5678);
    wr(A_HIB, 32'h0000_0042);
    peek(A_HIB, v); chk("R10 grant still usable", v, 32'h0000_0042);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule